// File: doc/BRIEF.md
# DRAM Refresh and Initialization Scheduler

This block decides when a DRAM that refreshes itself from its own internal row counter gets a refresh, and it drives the strobes for each one. After reset it holds everything idle for a power-up wait. It then runs a fixed burst of column-strobe-first refresh cycles. Only after that burst does it tell the host side that normal accesses may begin.

From then on, a free-running interval timer adds one owed refresh per interval. With the default 100 MHz clock, the interval is sized so that 512 rows are covered every 16 ms. A refresh waits while the host side reports an access in progress. The refreshes owed meanwhile are counted and then issued back to back.

Each refresh cycle has three phases. First, CAS is lowered with RAS still high. Next, RAS is lowered and held for a fixed width while CAS stays low. Finally, both strobes rise together and stay high through a precharge gap. The write enable output stays high throughout. The count of owed refreshes saturates at a ceiling. A sticky error flag reports that the count climbed past a lower limit.

Top module: `cbr_refresh_sched`

## Requirements
- R1: While reset is asserted, ras_n, cas_n and we_n are 1, and ref_req, host_ready and owed_err are 0; a later reset clears host_ready and owed_err again.
- R2: After reset is released, cas_n and ras_n stay high for at least PAUSE_CYC cycles, and the first CAS fall comes no later than PAUSE_CYC+2 cycles after release.
- R3: Exactly INIT_CYCLES refresh cycles are issued after the pause while host_ready is 0; host_ready rises only after the last of them has finished its precharge, and then stays 1.
- R4: In every refresh, cas_n is low for at least T_CSR cycles before ras_n falls; ras_n is low for exactly T_RAS cycles with cas_n low throughout; both rise in the same cycle; we_n is 1 at all times.
- R5: Between a RAS rise and the next CAS fall, both strobes are high for at least T_RP cycles.
- R6: Once host_ready is 1, one refresh is owed every INTERVAL_CYC cycles, so with host_busy at 0 consecutive CAS falls are exactly INTERVAL_CYC cycles apart.
- R7: No refresh starts while host_busy is 1, and ref_req is 1 while a refresh is owed or in progress.
- R8: When host_busy falls after K interval ticks, min(K, OWED_MAX) refreshes follow back to back before the next tick.
- R9: owed_err becomes 1 once the owed count exceeds OWED_LIMIT and stays 1 until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_busy | input | 1 | A host access is in progress; no refresh may start |
| ref_req | output | 1 | Refresh owed or running; host must not start a new access |
| host_ready | output | 1 | Initialization burst complete |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe for both byte lanes, active low |
| we_n | output | 1 | Write enable, held high |
| owed_err | output | 1 | Sticky: owed count passed OWED_LIMIT |

## Verification
The assertions assume that host_busy only rises outside a refresh cycle, since the host must see ref_req and hold off. They also assume that reset is held for at least one clock edge. The stimulus raises host_busy only some cycles after a refresh has completed, and lowers it before the next check window. Each deferral window is a whole number of intervals, started just after a tick, so the number of ticks it spans is exact.

// File: rtl/cbr_refresh_sched.sv
module cbr_refresh_sched #(
  parameter int CLK_MHZ      = 100,
  parameter int PAUSE_US     = 200,
  parameter int PERIOD_US    = 16000,
  parameter int ROWS         = 512,
  parameter int PAUSE_CYC    = CLK_MHZ * PAUSE_US,
  parameter int INTERVAL_CYC = CLK_MHZ * PERIOD_US / ROWS,
  parameter int INIT_CYCLES  = 8,
  parameter int T_CSR        = 1,
  parameter int T_RAS        = 5,
  parameter int T_RP         = 4,
  parameter int OWED_MAX     = 7,
  parameter int OWED_LIMIT   = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic host_busy,
  output logic ref_req,
  output logic host_ready,
  output logic ras_n,
  output logic cas_n,
  output logic we_n,
  output logic owed_err
);
  localparam int PW   = $clog2(PAUSE_CYC);
  localparam int IW   = $clog2(INTERVAL_CYC);
  localparam int TM1  = (T_RAS > T_RP) ? T_RAS : T_RP;
  localparam int TMAX = (TM1 > T_CSR) ? TM1 : T_CSR;
  localparam int TW   = $clog2(TMAX + 1);
  localparam int OW   = $clog2(OWED_MAX + 1);
  localparam int NW   = $clog2(INIT_CYCLES + 1);

  typedef enum logic [2:0] {ST_PAUSE, ST_IDLE, ST_CSR, ST_RAS, ST_PRE} st_t;

  st_t           st;
  logic [PW-1:0] pcnt;
  logic [TW-1:0] tcnt;
  logic [IW-1:0] icnt;
  logic [OW-1:0] owed;
  logic [NW-1:0] init_left;
  logic          init_done;

  logic pending, grant, tick, take, add, seq_end;
  logic [OW-1:0] owed_nx;

  assign pending = (init_left != '0) || (owed != '0);
  assign grant   = (st == ST_IDLE) && pending && !host_busy;
  assign tick    = init_done && (icnt == IW'(INTERVAL_CYC - 1));
  assign take    = grant && (init_left == '0);
  assign add     = tick && ((owed != OW'(OWED_MAX)) || take);
  assign owed_nx = owed + OW'(add) - OW'(take);
  assign seq_end = (st == ST_PRE) && (tcnt == '0);

  assign ras_n      = (st != ST_RAS);
  assign cas_n      = !((st == ST_CSR) || (st == ST_RAS));
  assign we_n       = 1'b1;
  assign host_ready = init_done;
  assign ref_req    = (st != ST_PAUSE) && (pending || (st != ST_IDLE));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st   <= ST_PAUSE;
      pcnt <= '0;
      tcnt <= '0;
    end else begin
      case (st)
        ST_PAUSE:
          if (pcnt == PW'(PAUSE_CYC - 1)) st <= ST_IDLE;
          else pcnt <= pcnt + 1'b1;
        ST_IDLE:
          if (grant) begin
            st   <= ST_CSR;
            tcnt <= TW'(T_CSR - 1);
          end
        ST_CSR:
          if (tcnt == '0) begin
            st   <= ST_RAS;
            tcnt <= TW'(T_RAS - 1);
          end else tcnt <= tcnt - 1'b1;
        ST_RAS:
          if (tcnt == '0) begin
            st   <= ST_PRE;
            tcnt <= TW'(T_RP - 1);
          end else tcnt <= tcnt - 1'b1;
        ST_PRE:
          if (tcnt == '0) st <= ST_IDLE;
          else tcnt <= tcnt - 1'b1;
        default: st <= ST_PAUSE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      init_left <= NW'(INIT_CYCLES);
      init_done <= 1'b0;
      icnt      <= '0;
      owed      <= '0;
      owed_err  <= 1'b0;
    end else begin
      if (grant && (init_left != '0)) init_left <= init_left - 1'b1;
      if (seq_end && (init_left == '0)) init_done <= 1'b1;
      if (!init_done || tick) icnt <= '0;
      else icnt <= icnt + 1'b1;
      owed <= owed_nx;
      if (owed > OW'(OWED_LIMIT)) owed_err <= 1'b1;
    end
  end

  a_r2_pause_first: assert property (@(posedge clk) disable iff (!rst_n)
    !cas_n |-> (pcnt == PW'(PAUSE_CYC - 1)));
  a_r3_ready_after_burst: assert property (@(posedge clk) disable iff (!rst_n)
    host_ready |-> (init_left == '0));
  a_r4_cas_leads_ras: assert property (@(posedge clk) disable iff (!rst_n)
    (!ras_n && $past(ras_n)) |-> $past(!cas_n));
  a_r5_precharge_gap: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ras_n) |=> cas_n);
  a_r6_no_debt_before_ready: assert property (@(posedge clk) disable iff (!rst_n)
    !host_ready |-> (owed == '0));
  a_r7_defer_to_host: assert property (@(posedge clk) disable iff (!rst_n)
    (cas_n && host_busy) |=> cas_n);
  a_r8_owed_capped: assert property (@(posedge clk) disable iff (!rst_n)
    owed <= OW'(OWED_MAX));
  a_r9_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    owed_err |=> owed_err);
endmodule

// File: tb/cbr_refresh_sched_tb.sv
module cbr_refresh_sched_tb;
  localparam int P  = 50;
  localparam int I  = 100;
  localparam int N  = 8;
  localparam int TC = 2;
  localparam int TR = 3;
  localparam int TP = 2;
  localparam int OM = 6;
  localparam int OL = 4;
  localparam int ROWS_T = 5;
  // columns: deferred intervals K, expected catch-up refreshes, expected owed_err
  localparam int TBL [ROWS_T][3] = '{'{1,1,0}, '{3,3,0}, '{4,4,0}, '{8,6,1}, '{5,5,1}};

  logic clk = 1'b0, rst_n = 1'b0, host_busy = 1'b0;
  logic ref_req, host_ready, ras_n, cas_n, we_n, owed_err;

  cbr_refresh_sched #(.PAUSE_CYC(P), .INTERVAL_CYC(I), .INIT_CYCLES(N), .T_CSR(TC),
    .T_RAS(TR), .T_RP(TP), .OWED_MAX(OM), .OWED_LIMIT(OL)) u_dut (
    .clk(clk), .rst_n(rst_n), .host_busy(host_busy), .ref_req(ref_req),
    .host_ready(host_ready), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n), .owed_err(owed_err));

  always #5 clk = ~clk;

  int checks = 0, errors = 0, cyc = 0;
  bit done = 1'b0;
  int cas_falls = 0, ras_rises = 0, last_fall = 0, prev_fall = 0;
  int hi_cnt = 0, csr_cnt = 0, ras_lo = 0;
  bit prev_cas = 1'b1, prev_ras = 1'b1, seen_rise = 1'b0, bad = 1'b0;

  task automatic chk(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  always @(posedge clk) cyc++;

  always @(negedge clk) begin
    if (!rst_n) begin
      prev_cas = 1'b1; prev_ras = 1'b1; seen_rise = 1'b0; bad = 1'b0;
      hi_cnt = 0; csr_cnt = 0; ras_lo = 0; cas_falls = 0; ras_rises = 0;
    end else begin
      if (prev_cas && !cas_n) begin
        cas_falls++;
        prev_fall = last_fall;
        last_fall = cyc;
        if (seen_rise) chk(hi_cnt >= TP, "R5 precharge gap", hi_cnt, TP);
      end
      if (prev_ras && !ras_n)
        chk(!prev_cas && !cas_n && csr_cnt >= TC, "R4 cas lead before ras", csr_cnt, TC);
      if (!prev_ras && ras_n) begin
        ras_rises++;
        chk(ras_lo == TR && cas_n && !bad, "R4 ras width and strobes", ras_lo, TR);
        if (ras_rises <= N) chk(!host_ready, "R3 ready low during burst", host_ready, 0);
        seen_rise = 1'b1;
        bad = 1'b0;
      end
      if (!ras_n) begin
        ras_lo = prev_ras ? 1 : ras_lo + 1;
        if (cas_n || !we_n) bad = 1'b1;
      end
      if (!cas_n && ras_n) csr_cnt = prev_cas ? 1 : csr_cnt + 1;
      if (cas_n && ras_n) hi_cnt = (prev_cas && prev_ras) ? hi_cnt + 1 : 1;
      prev_cas = cas_n;
      prev_ras = ras_n;
    end
  end

  task automatic step();
    @(posedge clk);
    #2;
  endtask

  task automatic wait_fall();
    int n = cas_falls;
    while (cas_falls == n) step();
  endtask

  initial begin
    int rel;
    int base;
    repeat (3) step();
    chk(ras_n && cas_n, "R1 strobes high in reset", {ras_n, cas_n}, 3);
    chk(we_n, "R1 we high in reset", we_n, 1);
    chk(!ref_req, "R1 no request in reset", ref_req, 0);
    chk(!host_ready, "R1 not ready in reset", host_ready, 0);
    chk(!owed_err, "R1 no error in reset", owed_err, 0);

    rst_n = 1'b1;
    rel = cyc;
    wait_fall();
    chk(last_fall - rel >= P && last_fall - rel <= P + 2, "R2 power-up pause", last_fall - rel, P + 1);
    chk(ref_req, "R7 request during init", ref_req, 1);
    chk(!host_ready, "R3 not ready at first refresh", host_ready, 0);

    while (!host_ready) step();
    chk(ras_rises == N, "R3 init burst count", ras_rises, N);
    chk(!owed_err, "R9 no error after init", owed_err, 0);

    wait_fall();
    wait_fall();
    chk(last_fall - prev_fall == I, "R6 idle refresh spacing", last_fall - prev_fall, I);

    for (int r = 0; r < ROWS_T; r++) begin
      wait_fall();
      repeat (10) step();
      host_busy = 1'b1;
      base = cas_falls;
      repeat (TBL[r][0] * I) step();
      chk(cas_falls == base, "R7 no refresh while busy", cas_falls - base, 0);
      chk(ref_req, "R7 request held while owed", ref_req, 1);
      host_busy = 1'b0;
      base = cas_falls;
      repeat (60) step();
      chk(cas_falls - base == TBL[r][1], "R8 catch-up count", cas_falls - base, TBL[r][1]);
      chk(owed_err == TBL[r][2][0], "R9 owed error flag", owed_err, TBL[r][2]);
      chk(host_ready, "R3 ready stays high", host_ready, 1);
    end

    rst_n = 1'b0;
    step();
    step();
    chk(!host_ready && !owed_err, "R1 reset clears ready and error", {host_ready, owed_err}, 0);
    chk(ras_n && cas_n && !ref_req, "R1 strobes idle in reset", {ras_n, cas_n, ref_req}, 6);
    rst_n = 1'b1;
    repeat (P - 1) step();
    chk(cas_falls == 0 && cas_n, "R2 pause after second reset", cas_falls, 0);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual %0d expected %0d", cyc, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule